// File: doc/BRIEF.md
# Clocked Serial Flash-Unlock Host

This block drives a synchronous, byte-wide serial link to the boot loader of a target microcontroller and presents that loader with a seven-byte flash access code. The host generates the serial clock. The target returns data on its own line and holds a busy line high while it is processing. A one-cycle `start` pulse runs one full exchange with no further control. The exchange is an unlock frame with a command byte, a three-byte code address, a length byte and the seven code bytes. A status-read command and two status reads follow. At the end the block reports whether the target granted access.

While it sends the frame, the block counts how many system clocks the target stays busy after the final code byte. It latches that count as a busy duration. Software that changes one candidate code byte per run can compare these durations across runs. A busy line that never falls ends the exchange with an error flag, so a stuck target cannot hang the host.

Top module: `sfu_unlock_host`

## Requirements
- R1: After reset, and whenever `active` is low, `sclk` is high. Also after reset, `done`, `unlock_ok`, `timeout_err`, `active` and `busy_time` are all zero.
- R2: Each byte is shifted least significant bit first. `txd` changes only at a falling `sclk` edge. `rxd` is sampled at the rising edge. Each low phase of `sclk` lasts CLK_DIV/2 system clocks.
- R3: One exchange sends exactly 15 bytes in this order: 0xF5, 0xDF, 0xFF, 0x0F, 0x07, `id_code[7:0]` through `id_code[55:48]` (seven bytes), 0x70, 0x00, 0x00.
- R4: `sclk` never falls to begin a byte while `busy_in` is high.
- R5: `busy_time` counts the system clocks during which the synchronised busy line is high after the last code byte completes, and it is latched when busy falls. One extra clock of target busy adds exactly one count. If busy has already fallen by the end of that byte, the value is 0. The value holds while the block is idle.
- R6: After the 15th byte, `done` pulses for one clock. At the same time `unlock_ok` is set to 1 exactly when bits [3:2] of the second status byte (the 15th byte received) are 2'b11. The first status byte has no effect.
- R7: If busy stays high for more than 2^TO_W system clocks, the exchange aborts. No further byte is sent, `done` pulses with `timeout_err`=1 and `unlock_ok`=0, and `sclk` stays high.
- R8: A `start` pulse while `active` is high is ignored. The running exchange still sends exactly the 15 bytes of R3.
- R9: After `done`, the block is idle. A new `start` clears `timeout_err` and `unlock_ok` and runs a fresh exchange.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that begins an exchange |
| id_code | input | 56 | Access code, byte 0 in bits [7:0] sent first |
| rxd | input | 1 | Serial data from target |
| busy_in | input | 1 | Target busy line, asynchronous |
| sclk | output | 1 | Serial clock driven to target, idles high |
| txd | output | 1 | Serial data to target |
| done | output | 1 | One-cycle pulse at end of exchange |
| unlock_ok | output | 1 | Target reported access granted |
| timeout_err | output | 1 | Exchange aborted on busy timeout |
| active | output | 1 | Exchange in progress |
| busy_time | output | DUR_W | Latched busy duration after last code byte |

## Verification
The bench plays the target. It logs every byte the host clocks in and drives status bytes whose other bits would mislead a design that decodes the wrong byte or the wrong field. A shifter that sends MSB first, or a frame with a wrong header or byte order, would fail the frame comparison. So would a design that restarts on a mid-run `start`. The busy counter is checked by the exact difference between two runs whose hold times differ by 33 clocks, and by a hold too short to reach the measurement, which must give zero; a counter that counts the wrong cycles or fails to clear shows up there. A busy line held past the timeout must end the run with the error flag, after exactly five bytes and within a narrow window. A design that hangs, keeps clocking, or reports success there would fail.

// File: rtl/sfu_pkg.sv
package sfu_pkg;

    localparam logic [7:0]  CMD_ID_CHECK    = 8'hF5;
    localparam logic [7:0]  CMD_READ_STATUS = 8'h70;
    localparam logic [23:0] ID_LOCATION     = 24'h0FFFDF;

    localparam int HDR_BYTES    = 5;
    localparam int ID_BYTES     = 7;
    localparam int FRAME_BYTES  = HDR_BYTES + ID_BYTES;
    localparam int STATUS_BYTES = 2;
    localparam int TOTAL_BYTES  = FRAME_BYTES + 1 + STATUS_BYTES;
    localparam int IDX_W        = $clog2(TOTAL_BYTES);

    typedef logic [IDX_W-1:0]      byte_idx_t;
    typedef logic [8*ID_BYTES-1:0] id_code_t;

    localparam byte_idx_t LAST_ID_IDX = byte_idx_t'(FRAME_BYTES - 1);
    localparam byte_idx_t LAST_IDX    = byte_idx_t'(TOTAL_BYTES - 1);

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_WAIT,
        SEQ_SHIFT,
        SEQ_MEASURE
    } seq_state_t;

    typedef struct packed {
        logic done;
        logic ok;
        logic err;
    } outcome_t;

    // Byte transmitted at a given position of the exchange.
    function automatic logic [7:0] frame_byte(input byte_idx_t idx, input id_code_t id);
        logic [7:0] b;
        b = 8'h00;
        if (idx == byte_idx_t'(0)) b = CMD_ID_CHECK;
        if (idx == byte_idx_t'(1)) b = ID_LOCATION[7:0];
        if (idx == byte_idx_t'(2)) b = ID_LOCATION[15:8];
        if (idx == byte_idx_t'(3)) b = ID_LOCATION[23:16];
        if (idx == byte_idx_t'(4)) b = 8'(ID_BYTES);
        for (int k = 0; k < ID_BYTES; k++) begin
            if (idx == byte_idx_t'(HDR_BYTES + k)) b = id[8*k +: 8];
        end
        if (idx == byte_idx_t'(FRAME_BYTES)) b = CMD_READ_STATUS;
        return b;
    endfunction

    function automatic logic unlock_granted(input logic [7:0] st);
        return st[3:2] == 2'b11;
    endfunction

endpackage

// File: rtl/sfu_sync.sv
module sfu_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sfu_shifter.sv
module sfu_shifter #(
    parameter int CLK_DIV = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic [7:0] tx_byte,
    input  logic       rxd,
    output logic       sclk,
    output logic       txd,
    output logic [7:0] rx_byte,
    output logic       fin,
    output logic       running
);
    localparam int HALF = CLK_DIV / 2;
    localparam int PW   = $clog2(HALF) + 1;
    localparam logic [PW-1:0] PHASE_END = PW'(HALF - 1);

    logic [PW-1:0] pcnt;
    logic [2:0]    bit_n;
    logic          high_ph;
    logic [7:0]    tx_sh;
    logic [7:0]    rx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            running <= 1'b0;
            sclk    <= 1'b1;
            txd     <= 1'b1;
            pcnt    <= '0;
            bit_n   <= '0;
            high_ph <= 1'b0;
            tx_sh   <= '0;
            rx_sh   <= '0;
            rx_byte <= '0;
            fin     <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (!running) begin
                if (go) begin
                    running <= 1'b1;
                    sclk    <= 1'b0;
                    txd     <= tx_byte[0];
                    tx_sh   <= tx_byte;
                    bit_n   <= '0;
                    high_ph <= 1'b0;
                    pcnt    <= '0;
                end
            end else if (pcnt != PHASE_END) begin
                pcnt <= pcnt + 1'b1;
            end else begin
                pcnt <= '0;
                if (!high_ph) begin
                    high_ph <= 1'b1;
                    sclk    <= 1'b1;
                    rx_sh   <= {rxd, rx_sh[7:1]};
                end else if (bit_n == 3'd7) begin
                    running <= 1'b0;
                    fin     <= 1'b1;
                    rx_byte <= rx_sh;
                end else begin
                    high_ph <= 1'b0;
                    sclk    <= 1'b0;
                    bit_n   <= bit_n + 3'd1;
                    txd     <= tx_sh[3'(bit_n + 3'd1)];
                end
            end
        end
    end
endmodule

// File: rtl/sfu_busy_timer.sv
module sfu_busy_timer #(
    parameter int TO_W  = 20,
    parameter int DUR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             busy_s,
    input  logic             watch,
    input  logic             measure,
    input  logic             clear,
    output logic             expired,
    output logic [DUR_W-1:0] duration
);
    localparam logic [TO_W:0] LIMIT = {1'b1, {TO_W{1'b0}}};

    logic [TO_W:0] wait_cnt;

    always_ff @(posedge clk) begin
        if (rst || !watch || !busy_s) wait_cnt <= '0;
        else if (wait_cnt != LIMIT)   wait_cnt <= wait_cnt + 1'b1;
    end

    assign expired = watch && busy_s && (wait_cnt == LIMIT);

    always_ff @(posedge clk) begin
        if (rst || clear)
            duration <= '0;
        else if (measure && busy_s && (duration != {DUR_W{1'b1}}))
            duration <= duration + 1'b1;
    end
endmodule

// File: rtl/sfu_sequencer.sv
module sfu_sequencer
    import sfu_pkg::*;
#(
    parameter int DUR_W = 24
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  id_code_t         id_code,
    input  logic             busy_s,
    input  logic             fin,
    input  logic [7:0]       rx_byte,
    input  logic             expired,
    input  logic [DUR_W-1:0] duration,
    output logic             go,
    output logic [7:0]       tx_byte,
    output logic             watch,
    output logic             measure,
    output logic             clear_dur,
    output logic             active,
    output outcome_t         result,
    output logic [DUR_W-1:0] busy_time
);
    seq_state_t state;
    byte_idx_t  idx;
    id_code_t   id_q;

    always_comb begin
        tx_byte   = frame_byte(idx, id_q);
        watch     = (state == SEQ_WAIT) || (state == SEQ_MEASURE);
        measure   = (state == SEQ_MEASURE);
        go        = (state == SEQ_WAIT) && !busy_s;
        clear_dur = (state == SEQ_IDLE) && start;
        active    = (state != SEQ_IDLE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SEQ_IDLE;
            idx       <= '0;
            id_q      <= '0;
            result    <= '0;
            busy_time <= '0;
        end else begin
            result.done <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        id_q       <= id_code;
                        idx        <= '0;
                        result.ok  <= 1'b0;
                        result.err <= 1'b0;
                        busy_time  <= '0;
                        state      <= SEQ_WAIT;
                    end
                end
                SEQ_WAIT: begin
                    if (expired) begin
                        result <= '{done: 1'b1, ok: 1'b0, err: 1'b1};
                        state  <= SEQ_IDLE;
                    end else if (!busy_s) begin
                        state <= SEQ_SHIFT;
                    end
                end
                SEQ_SHIFT: begin
                    if (fin) begin
                        if (idx == LAST_ID_IDX) begin
                            state <= SEQ_MEASURE;
                        end else if (idx == LAST_IDX) begin
                            result <= '{done: 1'b1, ok: unlock_granted(rx_byte), err: 1'b0};
                            state  <= SEQ_IDLE;
                        end else begin
                            idx   <= idx + 1'b1;
                            state <= SEQ_WAIT;
                        end
                    end
                end
                SEQ_MEASURE: begin
                    if (expired) begin
                        result <= '{done: 1'b1, ok: 1'b0, err: 1'b1};
                        state  <= SEQ_IDLE;
                    end else if (!busy_s) begin
                        busy_time <= duration;
                        idx       <= idx + 1'b1;
                        state     <= SEQ_WAIT;
                    end
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/sfu_unlock_host.sv
module sfu_unlock_host #(
    parameter int CLK_DIV     = 16,
    parameter int TO_W        = 20,
    parameter int DUR_W       = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [55:0]      id_code,
    input  logic             rxd,
    input  logic             busy_in,
    output logic             sclk,
    output logic             txd,
    output logic             done,
    output logic             unlock_ok,
    output logic             timeout_err,
    output logic             active,
    output logic [DUR_W-1:0] busy_time
);
    import sfu_pkg::*;

    logic             busy_s;
    logic             go;
    logic [7:0]       tx_byte;
    logic [7:0]       rx_byte;
    logic             fin;
    logic             shift_running;
    logic             watch;
    logic             measure;
    logic             clear_dur;
    logic             expired;
    logic [DUR_W-1:0] duration;
    outcome_t         result;

    sfu_sync #(.STAGES(SYNC_STAGES)) busy_sync_i (
        .clk (clk),
        .rst (rst),
        .d   (busy_in),
        .q   (busy_s)
    );

    sfu_shifter #(.CLK_DIV(CLK_DIV)) shifter_i (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .tx_byte (tx_byte),
        .rxd     (rxd),
        .sclk    (sclk),
        .txd     (txd),
        .rx_byte (rx_byte),
        .fin     (fin),
        .running (shift_running)
    );

    sfu_busy_timer #(.TO_W(TO_W), .DUR_W(DUR_W)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .busy_s   (busy_s),
        .watch    (watch),
        .measure  (measure),
        .clear    (clear_dur),
        .expired  (expired),
        .duration (duration)
    );

    sfu_sequencer #(.DUR_W(DUR_W)) seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .id_code   (id_code),
        .busy_s    (busy_s),
        .fin       (fin),
        .rx_byte   (rx_byte),
        .expired   (expired),
        .duration  (duration),
        .go        (go),
        .tx_byte   (tx_byte),
        .watch     (watch),
        .measure   (measure),
        .clear_dur (clear_dur),
        .active    (active),
        .result    (result),
        .busy_time (busy_time)
    );

    assign done        = result.done;
    assign unlock_ok   = result.ok;
    assign timeout_err = result.err;
endmodule

// File: rtl/sfu_unlock_host_chk.sv
module sfu_unlock_host_chk #(
    parameter int DUR_W = 24
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             sclk,
    input logic             txd,
    input logic             done,
    input logic             unlock_ok,
    input logic             timeout_err,
    input logic             active,
    input logic [DUR_W-1:0] busy_time,
    input logic             busy_s,
    input logic             shift_running
);
    assert_idle_clock_high_R1: assert property (@(posedge clk) disable iff (rst)
        !active |-> sclk);

    assert_txd_steady_high_R2: assert property (@(posedge clk) disable iff (rst)
        (sclk && $past(sclk)) |-> $stable(txd));

    assert_no_byte_into_busy_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(shift_running) |-> !$past(busy_s));

    assert_busy_time_held_R5: assert property (@(posedge clk) disable iff (rst)
        (!active && !start) |=> $stable(busy_time));

    assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_abort_not_ok_R7: assert property (@(posedge clk) disable iff (rst)
        (done && timeout_err) |-> !unlock_ok);

    assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
        done |-> !active);

    assert_flags_held_R9: assert property (@(posedge clk) disable iff (rst)
        (!active && !start) |=> ($stable(unlock_ok) && $stable(timeout_err)));
endmodule

bind sfu_unlock_host sfu_unlock_host_chk #(.DUR_W(DUR_W)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .sclk          (sclk),
    .txd           (txd),
    .done          (done),
    .unlock_ok     (unlock_ok),
    .timeout_err   (timeout_err),
    .active        (active),
    .busy_time     (busy_time),
    .busy_s        (busy_s),
    .shift_running (shift_running)
);

// File: tb/sfu_unlock_host_tb_top.sv
`timescale 1ns/1ps
module sfu_unlock_host_tb_top;
    localparam int CLK_DIV = 16;
    localparam int TO_W    = 12;
    localparam int DUR_W   = 16;
    localparam int HALF    = CLK_DIV / 2;
    localparam int LIMIT   = 1 << TO_W;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             start = 1'b0;
    logic [55:0]      id_code = '0;
    logic             rxd = 1'b1;
    logic             busy_in = 1'b0;
    logic             sclk, txd, done, unlock_ok, timeout_err, active;
    logic [DUR_W-1:0] busy_time;

    always #2.5 clk = ~clk;

    sfu_unlock_host #(.CLK_DIV(CLK_DIV), .TO_W(TO_W), .DUR_W(DUR_W)) dut_i (
        .clk(clk), .rst(rst), .start(start), .id_code(id_code), .rxd(rxd),
        .busy_in(busy_in), .sclk(sclk), .txd(txd), .done(done),
        .unlock_ok(unlock_ok), .timeout_err(timeout_err), .active(active),
        .busy_time(busy_time)
    );

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit cond, input string req, input string what,
                         input longint act, input longint exp);
        n_tests++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // ---------------- target model ----------------
    localparam logic [55:0] SECRET = 56'h00_FF_00_FF_FF_FF_FF;
    int         tgt_idx = 0;
    logic [7:0] rx_log [0:15];
    int         hold_tab [0:14];
    bit         stat_override = 1'b0;
    logic [7:0] stat_forced = 8'h00;
    int         busy_rise_cyc = 0;

    function automatic logic [7:0] target_out(input int k);
        bit match;
        match = 1'b1;
        for (int j = 0; j < 7; j++)
            if (rx_log[5+j] != SECRET[8*j +: 8]) match = 1'b0;
        if (k == 13) return 8'h8C;
        if (k == 14) return stat_override ? stat_forced : (match ? 8'h4C : 8'hB3);
        return 8'hFF;
    endfunction

    initial begin : target
        logic [7:0] outb;
        logic [7:0] inb;
        int my;
        forever begin
            @(negedge sclk);
            my   = tgt_idx;
            outb = target_out(my);
            for (int i = 0; i < 8; i++) begin
                if (i > 0) @(negedge sclk);
                #1 rxd = outb[i];
                @(posedge sclk);
                inb[i] = txd;
            end
            if (my < 16) rx_log[my] = inb;
            tgt_idx = my + 1;
            if (my < 15 && hold_tab[my] > 0) begin
                #1 busy_in = 1'b1;
                busy_rise_cyc = cyc;
                repeat (hold_tab[my]) @(posedge clk);
                #1 busy_in = 1'b0;
            end
        end
    end

    // -------- per-clock reference monitor (R1, R2, R4, R6) --------
    logic prev_sclk = 1'b1;
    logic prev_txd  = 1'b1;
    logic prev_done = 1'b0;
    int   run_len   = 0;
    int   mon_r1 = 0, mon_r2 = 0, mon_r4 = 0, mon_r6 = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (sclk != prev_sclk) begin
                if (sclk && run_len != HALF) mon_r2++;
                if (!sclk && busy_in) mon_r4++;
                run_len = 1;
            end else begin
                run_len++;
            end
            if (sclk && prev_sclk && txd != prev_txd) mon_r2++;
            if (!active && !sclk) mon_r1++;
            if (done && prev_done) mon_r6++;
        end
        prev_sclk = sclk;
        prev_txd  = txd;
        prev_done = done;
    end

    function automatic logic [7:0] exp_byte(input int k, input logic [55:0] id);
        case (k)
            0:  return 8'hF5;
            1:  return 8'hDF;
            2:  return 8'hFF;
            3:  return 8'h0F;
            4:  return 8'h07;
            12: return 8'h70;
            13, 14: return 8'h00;
            default: return id[8*(k-5) +: 8];
        endcase
    endfunction

    task automatic check_frame(input logic [55:0] id, input string req);
        int bad;
        int first;
        bad = 0;
        first = -1;
        for (int k = 0; k < 15; k++)
            if (rx_log[k] !== exp_byte(k, id)) begin
                bad++;
                if (first < 0) first = k;
            end
        if (first < 0) first = 0;
        check(bad == 0, req, $sformatf("frame byte %0d", first),
              rx_log[first], exp_byte(first, id));
        check(tgt_idx == 15, req, "byte count", tgt_idx, 15);
    endtask

    task automatic run_txn(input logic [55:0] id, input int last_hold,
                           input int sp_idx, input int sp_hold, input bit poke,
                           output bit got_ok, output bit got_err,
                           output int bt, output int done_cyc);
        for (int i = 0; i < 15; i++) hold_tab[i] = 3;
        hold_tab[11] = last_hold;
        if (sp_idx >= 0) hold_tab[sp_idx] = sp_hold;
        for (int i = 0; i < 16; i++) rx_log[i] = 8'h00;
        tgt_idx = 0;
        @(negedge clk);
        id_code = id;
        start   = 1'b1;
        @(negedge clk);
        start   = 1'b0;
        if (poke) begin
            repeat (300) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        got_ok   = unlock_ok;
        got_err  = timeout_err;
        bt       = busy_time;
        done_cyc = cyc;
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog run did not finish actual=%0d expected=0", cyc);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        bit ok, err;
        int bt, bt40, bt73, dcyc;
        logic [55:0] wrong;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check(sclk == 1'b1, "R1", "sclk after reset", sclk, 1);
        check(done == 1'b0 && active == 1'b0, "R1", "done/active after reset", {done, active}, 0);
        check(unlock_ok == 1'b0 && timeout_err == 1'b0, "R1", "flags after reset",
              {unlock_ok, timeout_err}, 0);
        check(busy_time == 0, "R1", "busy_time after reset", busy_time, 0);

        // Correct code, long busy after last code byte
        run_txn(SECRET, 40, -1, 0, 1'b0, ok, err, bt40, dcyc);
        check(ok == 1'b1 && err == 1'b0, "R6", "granted on bits[3:2]=11", {ok, err}, 2);
        check_frame(SECRET, "R3");
        check(bt40 >= 40 - HALF - 2 && bt40 <= 40, "R5", "busy_time for hold 40", bt40, 40 - HALF + 1);

        // Wrong code, longer busy: exact difference
        wrong = SECRET ^ 56'h01_00_00_00_00_00_00;
        run_txn(wrong, 73, -1, 0, 1'b0, ok, err, bt73, dcyc);
        check(ok == 1'b0 && err == 1'b0, "R6", "refused, first status byte ignored", {ok, err}, 0);
        check_frame(wrong, "R3");
        check(bt73 - bt40 == 33, "R5", "busy_time difference", bt73 - bt40, 33);

        // Forced status 0x08 (bits[3:2]=10), short busy, start poked mid-run
        stat_override = 1'b1;
        stat_forced   = 8'h08;
        run_txn(SECRET, 2, -1, 0, 1'b1, ok, err, bt, dcyc);
        check(ok == 1'b0, "R6", "bits[3:2]=10 not granted", ok, 0);
        check(bt == 0, "R5", "busy gone before measure", bt, 0);
        check_frame(SECRET, "R8");
        stat_override = 1'b0;

        // Busy stuck past the timeout at byte 4
        run_txn(SECRET, 3, 4, LIMIT + 300, 1'b0, ok, err, bt, dcyc);
        check(err == 1'b1 && ok == 1'b0, "R7", "abort flags", {ok, err}, 1);
        check(dcyc - busy_rise_cyc >= LIMIT && dcyc - busy_rise_cyc <= LIMIT + 16, "R7",
              "abort latency", dcyc - busy_rise_cyc, LIMIT + 4);
        while (busy_in) @(negedge clk);
        repeat (20) @(negedge clk);
        check(tgt_idx == 5, "R7", "bytes sent before abort", tgt_idx, 5);
        check(active == 1'b0 && sclk == 1'b1, "R7", "idle after abort", {active, sclk}, 1);

        // Fresh run after an abort
        run_txn(SECRET, 10, -1, 0, 1'b0, ok, err, bt, dcyc);
        check(ok == 1'b1 && err == 1'b0, "R9", "new run clears error", {ok, err}, 2);
        check_frame(SECRET, "R9");

        repeat (10) @(negedge clk);
        check(mon_r1 == 0, "R1", "sclk low while idle (clocks)", mon_r1, 0);
        check(mon_r2 == 0, "R2", "phase length / txd change in high phase", mon_r2, 0);
        check(mon_r4 == 0, "R4", "byte started while busy", mon_r4, 0);
        check(mon_r6 == 0, "R6", "done longer than one clock", mon_r6, 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule